// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor three 8-bit parallel ports, called A, B and C. Port C is handled as two 4-bit halves, upper and lower, and each half has its own direction. The processor side uses an 8-bit data bus, two address bits and active-low select, read and write strobes. Writes are sampled on the rising clock edge while both the select and the write strobe are low. Read data comes back combinationally while both the select and the read strobe are low.

One control address accepts two kinds of word, and bit 7 tells them apart. With bit 7 set, the word configures the port directions for basic input/output mode. With bit 7 clear, the word sets or clears one port C pin.

Pins are modelled as three separate vectors per port: input, output and output-enable. There are no tristate buffers. The handshake modes are not built. A configuration word that asks for a handshake mode is dropped.

Top module: `par_port_ctrl`

## Requirements
- R1: Address 00 selects port A, 01 selects port B and 10 selects port C. A write to one of these loads the port's output latch from `din`, and the new value appears on that port's output vector after the clock edge. While `cs_n` is high, a write changes no latch and no configuration.
- R2: While `cs_n` and `rd_n` are both low, `dout_oe` is 1 and `dout` carries the addressed data in the same cycle. In any other cycle, `dout` is 0 and `dout_oe` is 0.
- R3: `rst` is active high and acts on the clock edge. It sets every port group to input, which drives every output-enable to 0. It clears all three output latches. After reset, a read of address 11 returns 0x9B.
- R4: A configuration word has bit 7 = 1. In that word, bit 4 sets the port A direction, bit 3 the upper port C half, bit 1 port B and bit 0 the lower port C half, where 1 means input. Each output-enable bit is the inverse of its group's direction bit.
- R5: A control word with bit 7 = 1 and any of bits 6, 5 or 2 set is dropped. The directions and all three latches keep their values.
- R6: An accepted configuration word clears the output latches of A, B and C to 0.
- R7: A control word with bit 7 = 0 is a set/reset command. Bits 3:1 give the port C pin index (0 to 7) and bit 0 gives the new value. The command changes only that one bit of the port C latch.
- R8: A set/reset command leaves the port A and port B latches bit-identical. It also leaves every direction unchanged.
- R9: Input ports are not latched, so a read of an input port returns the live pins. A read of an output port returns its latch. A read of port C takes each half from the latch or from the pins according to that half's direction.
- R10: A read of address 11 returns the current configuration as {1, 0, 0, A dir, upper C dir, 0, B dir, lower C dir}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; write strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 00 A, 01 B, 10 C, 11 control |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor, 0 when not reading |
| dout_oe | output | 1 | High while a read is being answered |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output-enable, all bits equal |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output-enable, all bits equal |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output-enable, one value per 4-bit half |

## Verification
The assertions assume that the strobes and `din` are synchronous to `clk` and settle before the rising edge. They also assume that each strobe low phase is meant as one or more identical writes. Repeating a write is harmless: a latch load, a configuration word and a set/reset command all give the same state when applied twice.

The assertions further assume that reset is asserted from the first clock edge. The bench meets these assumptions by changing every bus input only on the falling edge. It asserts reset before the first rising edge. Each write strobe covers exactly one rising edge, and each read strobe covers none, so a read never coincides with a write.

// File: rtl/ppc_pkg.sv
// Shared types and helpers for the parallel port controller.
// Assumes an 8-bit control word; the field positions below are fixed by the
// configuration and set/reset word formats.
package ppc_pkg;

    // Register selected by the two address bits.
    typedef enum logic [1:0] {
        SEL_A   = 2'b00,
        SEL_B   = 2'b01,
        SEL_C   = 2'b10,
        SEL_CTL = 2'b11
    } ppc_sel_e;

    // Direction of each port group; 1 means input.
    typedef struct packed {
        logic a_in;
        logic cu_in;
        logic b_in;
        logic cl_in;
    } ppc_cfg_t;

    localparam ppc_cfg_t CFG_ALL_IN = '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};

    // True when a control word is a well-formed basic-mode configuration.
    function automatic logic is_basic_cfg(input logic [7:0] w);
        return w[7] && (w[6:5] == 2'b00) && !w[2];
    endfunction

    // Rebuild the control word that a configuration corresponds to.
    function automatic logic [7:0] cfg_to_word(input ppc_cfg_t c);
        return {1'b1, 2'b00, c.a_in, c.cu_in, 1'b0, c.b_in, c.cl_in};
    endfunction

endpackage

// File: rtl/ppc_bus_decode.sv
// Processor bus decoder.
// Turns select, strobes and address into one-cycle write enables and a read
// qualifier. Assumes the strobes are synchronous to the core clock.
module ppc_bus_decode
    import ppc_pkg::*;
(
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    input  logic [7:0] din,
    output logic       wr_a,
    output logic       wr_b,
    output logic       wr_c,
    output logic       wr_cfg,
    output logic       wr_bsr,
    output logic       rd_act,
    output ppc_sel_e   rd_sel
);

    logic     wr_act;
    logic     wr_ctl;
    ppc_sel_e sel;

    // Qualify the strobes with chip select and decode the target register.
    always_comb begin
        sel    = ppc_sel_e'(addr);
        wr_act = !cs_n && !wr_n;
        rd_act = !cs_n && !rd_n;
        rd_sel = sel;
        wr_a   = wr_act && (sel == SEL_A);
        wr_b   = wr_act && (sel == SEL_B);
        wr_c   = wr_act && (sel == SEL_C);
        wr_ctl = wr_act && (sel == SEL_CTL);
        wr_cfg = wr_ctl && is_basic_cfg(din);
        wr_bsr = wr_ctl && !din[7];
    end

endmodule

// File: rtl/ppc_cfg_reg.sv
// Direction register.
// Holds the four group directions. It loads only from a well-formed
// basic-mode word, which the decoder has already qualified.
// Uses a synchronous active-low reset that selects all inputs.
module ppc_cfg_reg
    import ppc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_cfg,
    input  logic [7:0] din,
    output ppc_cfg_t   cfg,
    output logic [7:0] cfg_word
);

    // Capture the direction fields of an accepted configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_ALL_IN;
        end else if (wr_cfg) begin
            cfg <= '{a_in: din[4], cu_in: din[3], b_in: din[1], cl_in: din[0]};
        end
    end

    // Present the stored configuration in control-word form for read-back.
    always_comb begin
        cfg_word = cfg_to_word(cfg);
    end

endmodule

// File: rtl/ppc_port_latch.sv
// Output latch of one port.
// The register can be cleared, loaded whole, or, when BSR_EN is set,
// updated one bit at a time. Clear has priority over load, and load has
// priority over a single-bit update.
// Uses a synchronous active-low reset that clears the latch.
module ppc_port_latch #(
    parameter int W      = 8,
    parameter bit BSR_EN = 1'b0,
    localparam int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic [W-1:0]     ld_data,
    input  logic             bit_we,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    output logic [W-1:0]     q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic hit;
        logic r;

        // Decide whether a single-bit command targets this bit.
        assign hit = BSR_EN && bit_we && (bit_idx == IDX_W'(i));

        // Update this bit of the latch.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= 1'b0;
            end else if (clr) begin
                r <= 1'b0;
            end else if (ld) begin
                r <= ld_data[i];
            end else if (hit) begin
                r <= bit_val;
            end
        end

        assign q[i] = r;
    end

endmodule

// File: rtl/ppc_read_mux.sv
// Read-data multiplexer.
// Picks the latch or the live pins for each port group according to its
// direction, and returns the control word at the control address. The
// output is 0 whenever no read is active. Purely combinational.
module ppc_read_mux
    import ppc_pkg::*;
#(
    parameter int W = 8,
    localparam int HALF = W / 2
) (
    input  logic         rd_act,
    input  ppc_sel_e     rd_sel,
    input  ppc_cfg_t     cfg,
    input  logic [7:0]   cfg_word,
    input  logic [W-1:0] a_lat,
    input  logic [W-1:0] b_lat,
    input  logic [W-1:0] c_lat,
    input  logic [W-1:0] pa_in,
    input  logic [W-1:0] pb_in,
    input  logic [W-1:0] pc_in,
    output logic [W-1:0] dout,
    output logic         dout_oe
);

    logic [W-1:0] a_val;
    logic [W-1:0] b_val;
    logic [W-1:0] c_val;

    // Choose the pins or the latch for each group.
    always_comb begin
        a_val = cfg.a_in ? pa_in : a_lat;
        b_val = cfg.b_in ? pb_in : b_lat;
        c_val[W-1:HALF] = cfg.cu_in ? pc_in[W-1:HALF] : c_lat[W-1:HALF];
        c_val[HALF-1:0] = cfg.cl_in ? pc_in[HALF-1:0] : c_lat[HALF-1:0];
    end

    // Drive the selected value only while a read is active.
    always_comb begin
        dout    = '0;
        dout_oe = rd_act;
        if (rd_act) begin
            unique case (rd_sel)
                SEL_A:   dout = a_val;
                SEL_B:   dout = b_val;
                SEL_C:   dout = c_val;
                SEL_CTL: dout = W'(cfg_word);
            endcase
        end
    end

endmodule

// File: rtl/par_port_ctrl.sv
// Top level of the programmable parallel port controller.
// Wires together the bus decoder, the direction register, the three port
// latches and the read multiplexer, and derives the output-enables from
// the directions. Assumes DATA_W is 8: the control word layout requires it.
// The external reset is active high. Inside, it becomes the synchronous
// active-low reset that every submodule uses.
module par_port_ctrl
    import ppc_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int HALF  = DATA_W / 2,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] pc_oe
);

    logic       rst_n;
    logic       wr_a, wr_b, wr_c, wr_cfg, wr_bsr, rd_act;
    ppc_sel_e   rd_sel;
    ppc_cfg_t   cfg;
    logic [7:0] cfg_word;

    // Convert the external reset to the internal active-low form.
    assign rst_n = !rst;

    ppc_bus_decode u_dec (
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .addr   (addr),
        .din    (din[7:0]),
        .wr_a   (wr_a),
        .wr_b   (wr_b),
        .wr_c   (wr_c),
        .wr_cfg (wr_cfg),
        .wr_bsr (wr_bsr),
        .rd_act (rd_act),
        .rd_sel (rd_sel)
    );

    ppc_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cfg   (wr_cfg),
        .din      (din[7:0]),
        .cfg      (cfg),
        .cfg_word (cfg_word)
    );

    ppc_port_latch #(.W(DATA_W), .BSR_EN(1'b0)) u_lat_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wr_cfg),
        .ld      (wr_a),
        .ld_data (din),
        .bit_we  (1'b0),
        .bit_idx (din[IDX_W:1]),
        .bit_val (din[0]),
        .q       (pa_out)
    );

    ppc_port_latch #(.W(DATA_W), .BSR_EN(1'b0)) u_lat_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wr_cfg),
        .ld      (wr_b),
        .ld_data (din),
        .bit_we  (1'b0),
        .bit_idx (din[IDX_W:1]),
        .bit_val (din[0]),
        .q       (pb_out)
    );

    ppc_port_latch #(.W(DATA_W), .BSR_EN(1'b1)) u_lat_c (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wr_cfg),
        .ld      (wr_c),
        .ld_data (din),
        .bit_we  (wr_bsr),
        .bit_idx (din[IDX_W:1]),
        .bit_val (din[0]),
        .q       (pc_out)
    );

    // Drive each output-enable as the inverse of its group's direction.
    always_comb begin
        pa_oe              = {DATA_W{!cfg.a_in}};
        pb_oe              = {DATA_W{!cfg.b_in}};
        pc_oe[DATA_W-1:HALF] = {HALF{!cfg.cu_in}};
        pc_oe[HALF-1:0]      = {HALF{!cfg.cl_in}};
    end

    ppc_read_mux #(.W(DATA_W)) u_rd (
        .rd_act   (rd_act),
        .rd_sel   (rd_sel),
        .cfg      (cfg),
        .cfg_word (cfg_word),
        .a_lat    (pa_out),
        .b_lat    (pb_out),
        .c_lat    (pc_out),
        .pa_in    (pa_in),
        .pb_in    (pb_in),
        .pc_in    (pc_in),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

endmodule

// File: rtl/par_port_ctrl_chk.sv
// Assertion checker for par_port_ctrl, attached to it by the bind below.
// Watches only the top-level ports.
module par_port_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe,
    input logic [DATA_W-1:0] pa_out,
    input logic [DATA_W-1:0] pa_oe,
    input logic [DATA_W-1:0] pb_out,
    input logic [DATA_W-1:0] pb_oe,
    input logic [DATA_W-1:0] pc_out,
    input logic [DATA_W-1:0] pc_oe
);

    logic ctl_wr, good_cfg, bad_cfg, bsr_cmd;

    // Classify control-address writes from the bus pins.
    always_comb begin
        ctl_wr   = !cs_n && !wr_n && (addr == 2'b11);
        good_cfg = ctl_wr && din[7] && (din[6:5] == 2'b00) && !din[2];
        bad_cfg  = ctl_wr && din[7] && !good_cfg;
        bsr_cmd  = ctl_wr && !din[7];
    end

    p_reset_state_r3: assert property (@(posedge clk)
        rst |=> (pa_oe == '0) && (pb_oe == '0) && (pc_oe == '0)
                && (pa_out == '0) && (pb_out == '0) && (pc_out == '0));

    p_deselect_hold_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out)
                 && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe));

    p_read_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (dout == '0) && !dout_oe);

    p_oe_uniform_r4: assert property (@(posedge clk) disable iff (rst)
        ((pa_oe == '0) || (pa_oe == '1)) && ((pb_oe == '0) || (pb_oe == '1)));

    p_bad_cfg_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        bad_cfg |=> $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)
                    && $stable(pa_out) && $stable(pb_out) && $stable(pc_out));

    p_cfg_clears_r6: assert property (@(posedge clk) disable iff (rst)
        good_cfg |=> (pa_out == '0) && (pb_out == '0) && (pc_out == '0));

    p_bsr_one_bit_r7: assert property (@(posedge clk) disable iff (rst)
        bsr_cmd |=> ($countones(pc_out ^ $past(pc_out)) <= 1));

    p_bsr_keeps_ab_r8: assert property (@(posedge clk) disable iff (rst)
        bsr_cmd |=> $stable(pa_out) && $stable(pb_out)
                    && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe));

endmodule

bind par_port_ctrl par_port_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr    (addr),
    .din     (din),
    .dout    (dout),
    .dout_oe (dout_oe),
    .pa_out  (pa_out),
    .pa_oe   (pa_oe),
    .pb_out  (pb_out),
    .pb_oe   (pb_oe),
    .pc_out  (pc_out),
    .pc_oe   (pc_oe)
);

// File: tb/test_par_port_ctrl.sv
// Self-checking bench for par_port_ctrl. A vector table is walked first,
// then directed tests cover reset, deselect, idle read and set/reset.
module test_par_port_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic [7:0] din = 8'h00;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic       dout_oe;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    par_port_ctrl i_par_port_ctrl (
        .clk (clk), .rst (rst), .cs_n (cs_n), .rd_n (rd_n), .wr_n (wr_n),
        .addr (addr), .din (din), .dout (dout), .dout_oe (dout_oe),
        .pa_in (pa_in), .pa_out (pa_out), .pa_oe (pa_oe),
        .pb_in (pb_in), .pb_out (pb_out), .pb_oe (pb_oe),
        .pc_in (pc_in), .pc_out (pc_out), .pc_oe (pc_oe)
    );

    // op: 0 write, 1 read. sel: 0 dout, 1 pa_out, 2 pb_out, 3 pc_out,
    // 4 = {pa_oe[0], pc_oe[7], pb_oe[0], pc_oe[0]}.
    typedef struct packed {
        logic       op;
        logic [1:0] adr;
        logic [7:0] dat;
        logic [7:0] pai;
        logic [7:0] pbi;
        logic [7:0] pci;
        logic [2:0] sel;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd3, 8'h80, 8'h00, 8'h00, 8'h00, 3'd4, 8'h0F, 4'd4},  // R4 all outputs
        '{1'b0, 2'd0, 8'h5A, 8'h00, 8'h00, 8'h00, 3'd1, 8'h5A, 4'd1},  // R1
        '{1'b0, 2'd1, 8'hC3, 8'h00, 8'h00, 8'h00, 3'd2, 8'hC3, 4'd1},  // R1
        '{1'b0, 2'd2, 8'h96, 8'h00, 8'h00, 8'h00, 3'd3, 8'h96, 4'd1},  // R1
        '{1'b1, 2'd0, 8'h00, 8'hFF, 8'h00, 8'h00, 3'd0, 8'h5A, 4'd2},  // R2 output reads latch
        '{1'b1, 2'd2, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 8'h96, 4'd2},  // R2
        '{1'b0, 2'd3, 8'h01, 8'h00, 8'h00, 8'h00, 3'd3, 8'h97, 4'd7},  // R7 set bit 0
        '{1'b0, 2'd3, 8'h0E, 8'h00, 8'h00, 8'h00, 3'd3, 8'h17, 4'd7},  // R7 clear bit 7
        '{1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 8'h00, 3'd1, 8'h5A, 4'd8},  // R8 A kept
        '{1'b1, 2'd1, 8'h00, 8'h00, 8'h00, 8'h00, 3'd2, 8'hC3, 4'd8},  // R8 B kept
        '{1'b1, 2'd3, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 8'h80, 4'd10}, // R10
        '{1'b0, 2'd3, 8'h8A, 8'h00, 8'h00, 8'h00, 3'd4, 8'h09, 4'd4},  // R4 mixed
        '{1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 8'h00, 3'd1, 8'h00, 4'd6},  // R6 A cleared
        '{1'b1, 2'd2, 8'h00, 8'h00, 8'h00, 8'h00, 3'd3, 8'h00, 4'd6},  // R6 C cleared
        '{1'b0, 2'd2, 8'h3C, 8'h00, 8'h00, 8'h00, 3'd3, 8'h3C, 4'd1},  // R1
        '{1'b1, 2'd2, 8'h00, 8'h00, 8'h00, 8'hA5, 3'd0, 8'hAC, 4'd9},  // R9 mixed halves
        '{1'b1, 2'd1, 8'h00, 8'h00, 8'h66, 8'h00, 3'd0, 8'h66, 4'd9},  // R9 live pins
        '{1'b1, 2'd1, 8'h00, 8'h00, 8'h99, 8'h00, 3'd0, 8'h99, 4'd9},  // R9 live pins
        '{1'b0, 2'd3, 8'hA0, 8'h00, 8'h00, 8'h00, 3'd4, 8'h09, 4'd5},  // R5 dropped
        '{1'b1, 2'd3, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 8'h8A, 4'd5},  // R5
        '{1'b0, 2'd3, 8'h84, 8'h00, 8'h00, 8'h00, 3'd3, 8'h3C, 4'd5},  // R5 latch kept
        '{1'b0, 2'd3, 8'h0F, 8'h00, 8'h00, 8'h00, 3'd4, 8'h09, 4'd8},  // R8 dirs kept
        '{1'b1, 2'd2, 8'h00, 8'h00, 8'h00, 8'h05, 3'd0, 8'h0C, 4'd9},  // R9
        '{1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 8'h00, 3'd3, 8'hBC, 4'd7}   // R7
    };

    // Compare one value, count it and report a miscompare.
    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] probe(input logic [2:0] s);
        case (s)
            3'd1:    return pa_out;
            3'd2:    return pb_out;
            3'd3:    return pc_out;
            3'd4:    return {4'h0, pa_oe[0], pc_oe[7], pb_oe[0], pc_oe[0]};
            default: return dout;
        endcase
    endfunction

    // One write: strobe spans exactly one rising edge.
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    // One read: strobe stays between edges; data sampled 1 ns in.
    task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1;
        d  = dout;
        oe = dout_oe;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        logic       roe;
        logic [7:0] ref_c;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R3: state after reset.
        check("R3 oe", probe(3'd4), 8'h00);
        check("R3 pa_out", pa_out, 8'h00);
        check("R3 pc_out", pc_out, 8'h00);
        bus_read(2'd3, rv, roe);
        check("R3 ctl word", rv, 8'h9B);

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            logic [7:0] got;
            pa_in = VECS[i].pai; pb_in = VECS[i].pbi; pc_in = VECS[i].pci;
            if (VECS[i].op == 1'b0) begin
                bus_write(VECS[i].adr, VECS[i].dat);
                got = probe(VECS[i].sel);
            end else begin
                bus_read(VECS[i].adr, rv, roe);
                got = (VECS[i].sel == 3'd0) ? rv : probe(VECS[i].sel);
            end
            check($sformatf("R%0d vector %0d", VECS[i].req, i), got, VECS[i].exp);
        end

        // R2: read strobe sets dout_oe; no strobe gives idle bus.
        bus_read(2'd1, rv, roe);
        check("R2 dout_oe on read", {7'h0, roe}, 8'h01);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b1; addr = 2'd3;
        #1;
        check("R2 idle dout", dout, 8'h00);
        check("R2 idle dout_oe", {7'h0, dout_oe}, 8'h00);
        cs_n = 1'b1;

        // R1: write with chip select high is ignored.
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'h11);
        bus_write(2'd1, 8'h22);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; din = 8'hFF;
        @(negedge clk);
        wr_n = 1'b1;
        check("R1 deselected write", pa_out, 8'h11);

        // R7, R8: set each port C bit in turn.
        ref_c = 8'h00;
        for (int b = 0; b < 8; b++) begin
            bus_write(2'd3, {4'h0, 3'(b), 1'b1});
            ref_c[b] = 1'b1;
            check($sformatf("R7 bsr set %0d", b), pc_out, ref_c);
            check("R8 pa kept", pa_out, 8'h11);
            check("R8 pb kept", pb_out, 8'h22);
        end
        bus_write(2'd3, 8'h08);   // clear bit 4
        ref_c[4] = 1'b0;
        check("R7 bsr clear 4", pc_out, ref_c);
        check("R8 oe kept", probe(3'd4), 8'h0F);

        // R3: reset in mid-run.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R3 oe after reset", probe(3'd4), 8'h00);
        check("R3 pb_out after reset", pb_out, 8'h00);
        bus_read(2'd3, rv, roe);
        check("R3 ctl after reset", rv, 8'h9B);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule